// File: doc/BRIEF.md
# Control Endpoint OUT Transfer Tracker

This block keeps the bookkeeping for the OUT direction of a USB device's control endpoint. Software programs one 32-bit transfer-size register while the endpoint is disabled. The register holds a byte budget, a one-bit data packet count and a budget for back-to-back SETUP packets. Software then raises the endpoint enable. From that point the hardware owns the register. The packet count drops when a packet lands in the receive FIFO. The byte budget drops later, when that packet is drained from the FIFO to memory.

The transfer completes when the byte budget is used up, or when a short packet is drained. At completion the block pulses its interrupt and clears the enable in the same cycle, which hands the register back to software. SETUP packets use their own small budget. A SETUP pulse that arrives with the budget empty is refused and flagged.

Top module: `ep0_out_xfer_tracker`

## Requirements
- R1: After reset the register reads 0x0000_0000, the enable is low, and the interrupt and overflow outputs are low.
- R2: While the endpoint is disabled, a register write loads bits 6:0 as the byte budget, bit 19 as the packet count and bits 30:29 as the SETUP budget (01 = 1, 10 = 2, 11 = 3 packets). All other bits read as zero whatever was written. The new value is readable one cycle after the write.
- R3: A register write issued while the endpoint is enabled has no effect on the register.
- R4: While enabled, each packet-written pulse takes the packet count to zero. A pulse that arrives when the count is already zero leaves it at zero.
- R5: While enabled, a drain pulse subtracts its byte count from the byte budget. The result saturates at zero.
- R6: A drain that leaves the byte budget at zero completes the transfer. One cycle later the interrupt is high for exactly one cycle and the enable is low in that same cycle.
- R7: A drained packet shorter than the maximum packet size (64 bytes by default) also completes the transfer, whatever budget remains. A zero-length packet counts as short.
- R8: While enabled, a SETUP pulse decrements a nonzero SETUP budget. When the budget is 00, the pulse leaves it at 00 and raises the overflow output for one cycle on the next cycle.
- R9: While disabled, the packet-written, drain and SETUP pulses change nothing and raise neither the interrupt nor the overflow output.
- R10: A packet-written pulse and a drain pulse in the same cycle both take effect.
- R11: An enable-set pulse while disabled raises the enable on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data |
| epEnableSet | input | 1 | Software request to enable the endpoint |
| epEnable | output | 1 | Endpoint enable (hardware owns the register while high) |
| pktWrPulse | input | 1 | A packet was written into the receive FIFO |
| pktRdPulse | input | 1 | A packet was drained from the FIFO to memory |
| pktRdBytes | input | 7 | Byte count of the drained packet |
| setupPulse | input | 1 | A SETUP packet was received |
| xferIrq | output | 1 | Transfer-complete interrupt pulse |
| setupOvf | output | 1 | SETUP received with an empty SETUP budget |

## Verification
The packet count and the byte budget are decremented from two different pipeline points, so a FIFO write and a FIFO drain can land in the same cycle. The bench provokes this by driving both pulses in a single cycle on a full-packet drain. That drain also empties the budget, so completion happens on the same edge. The scoreboard judges the result by expecting the packet bit cleared, the budget at zero, the interrupt high and the enable low, all on the following cycle.

// File: rtl/ep0_trk_pkg.sv
package ep0_trk_pkg;
  // Field positions are fixed because software decodes them.
  localparam int SETUP_LSB = 29;
  localparam int PKT_BIT   = 19;

  typedef struct packed {
    logic load;
    logic decPkt;
    logic decSize;
    logic decSetup;
  } trkStrobe_t;
endpackage

// File: rtl/ep0_trk_datapath.sv
module ep0_trk_datapath
  import ep0_trk_pkg::*;
#(
  parameter int SIZE_W  = 7,
  parameter int SETUP_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  trkStrobe_t         stb,
  input  logic [31:0]        wrData,
  input  logic [SIZE_W-1:0]  drainBytes,
  output logic [SETUP_W-1:0] setupCnt,
  output logic               pktCnt,
  output logic [SIZE_W-1:0]  xferSize,
  output logic               drainEmpties,
  output logic               setupEmpty
);
  assign drainEmpties = (drainBytes >= xferSize);
  assign setupEmpty   = (setupCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupCnt <= '0;
      pktCnt   <= 1'b0;
      xferSize <= '0;
    end else if (stb.load) begin
      setupCnt <= wrData[SETUP_LSB +: SETUP_W];
      pktCnt   <= wrData[PKT_BIT];
      xferSize <= wrData[SIZE_W-1:0];
    end else begin
      if (stb.decPkt)   pktCnt   <= 1'b0;
      if (stb.decSize)  xferSize <= drainEmpties ? '0 : xferSize - drainBytes;
      if (stb.decSetup) setupCnt <= setupCnt - 1'b1;
    end
  end
endmodule

// File: rtl/ep0_trk_ctrl.sv
module ep0_trk_ctrl
  import ep0_trk_pkg::*;
#(
  parameter int SIZE_W  = 7,
  parameter int MAX_PKT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              epEnableSet,
  input  logic              pktWrPulse,
  input  logic              pktRdPulse,
  input  logic [SIZE_W-1:0] pktRdBytes,
  input  logic              setupPulse,
  input  logic              drainEmpties,
  input  logic              setupEmpty,
  output trkStrobe_t        stb,
  output logic              epEnable,
  output logic              xferIrq,
  output logic              setupOvf
);
  localparam logic [SIZE_W:0] MAX_PKT_V = MAX_PKT[SIZE_W:0];

  logic shortPkt;
  logic xferDone;

  always_comb begin
    shortPkt     = {1'b0, pktRdBytes} < MAX_PKT_V;
    stb.load     = !epEnable && regWrEn;
    stb.decPkt   = epEnable && pktWrPulse;
    stb.decSize  = epEnable && pktRdPulse;
    stb.decSetup = epEnable && setupPulse && !setupEmpty;
    xferDone     = stb.decSize && (drainEmpties || shortPkt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epEnable <= 1'b0;
      xferIrq  <= 1'b0;
      setupOvf <= 1'b0;
    end else begin
      xferIrq  <= xferDone;
      setupOvf <= epEnable && setupPulse && setupEmpty;
      if (xferDone)                      epEnable <= 1'b0;
      else if (!epEnable && epEnableSet) epEnable <= 1'b1;
    end
  end
endmodule

// File: rtl/ep0_out_xfer_tracker.sv
module ep0_out_xfer_tracker
  import ep0_trk_pkg::*;
#(
  parameter int SIZE_W  = 7,
  parameter int SETUP_W = 2,
  parameter int MAX_PKT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              epEnableSet,
  output logic              epEnable,
  input  logic              pktWrPulse,
  input  logic              pktRdPulse,
  input  logic [SIZE_W-1:0] pktRdBytes,
  input  logic              setupPulse,
  output logic              xferIrq,
  output logic              setupOvf
);
  trkStrobe_t         stb;
  logic [SETUP_W-1:0] setupCnt;
  logic               pktCnt;
  logic [SIZE_W-1:0]  xferSize;
  logic               drainEmpties;
  logic               setupEmpty;

  ep0_trk_ctrl #(.SIZE_W(SIZE_W), .MAX_PKT(MAX_PKT)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .epEnableSet(epEnableSet),
    .pktWrPulse(pktWrPulse), .pktRdPulse(pktRdPulse), .pktRdBytes(pktRdBytes),
    .setupPulse(setupPulse), .drainEmpties(drainEmpties), .setupEmpty(setupEmpty),
    .stb(stb), .epEnable(epEnable), .xferIrq(xferIrq), .setupOvf(setupOvf)
  );

  ep0_trk_datapath #(.SIZE_W(SIZE_W), .SETUP_W(SETUP_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .drainBytes(pktRdBytes),
    .setupCnt(setupCnt), .pktCnt(pktCnt), .xferSize(xferSize),
    .drainEmpties(drainEmpties), .setupEmpty(setupEmpty)
  );

  always_comb begin
    regRdData = '0;
    regRdData[SIZE_W-1:0]           = xferSize;
    regRdData[PKT_BIT]              = pktCnt;
    regRdData[SETUP_LSB +: SETUP_W] = setupCnt;
  end
endmodule

// File: rtl/ep0_trk_checker.sv
module ep0_trk_checker #(
  parameter int SIZE_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [31:0]       regRdData,
  input logic              epEnable,
  input logic              pktWrPulse,
  input logic              pktRdPulse,
  input logic              setupPulse,
  input logic              xferIrq,
  input logic              setupOvf
);
  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    epEnable && regWrEn && !pktWrPulse && !pktRdPulse && !setupPulse |=> $stable(regRdData)); // R3

  AST_PKT_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    epEnable |=> !$rose(regRdData[19])); // R4

  AST_SIZE_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    epEnable |=> regRdData[SIZE_W-1:0] <= $past(regRdData[SIZE_W-1:0])); // R5

  AST_IRQ_DROPS_EN: assert property (@(posedge clk) disable iff (!rstN)
    xferIrq |-> !epEnable && $past(epEnable) && $past(pktRdPulse)); // R6

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    xferIrq |=> !xferIrq); // R6

  AST_SETUP_OVF: assert property (@(posedge clk) disable iff (!rstN)
    setupOvf |-> $past(setupPulse) && regRdData[30:29] == 2'b00); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !epEnable |=> !xferIrq && !setupOvf); // R9
endmodule

bind ep0_out_xfer_tracker ep0_trk_checker #(.SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdData(regRdData),
  .epEnable(epEnable), .pktWrPulse(pktWrPulse), .pktRdPulse(pktRdPulse),
  .setupPulse(setupPulse), .xferIrq(xferIrq), .setupOvf(setupOvf)
);

// File: tb/sim_ep0_out_xfer_tracker.sv
`timescale 1ns/1ps
module sim_ep0_out_xfer_tracker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic epEnableSet = 1'b0;
  logic epEnable;
  logic pktWrPulse = 1'b0;
  logic pktRdPulse = 1'b0;
  logic [6:0] pktRdBytes = '0;
  logic setupPulse = 1'b0;
  logic xferIrq;
  logic setupOvf;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ep0_out_xfer_tracker u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .epEnableSet(epEnableSet), .epEnable(epEnable),
    .pktWrPulse(pktWrPulse), .pktRdPulse(pktRdPulse), .pktRdBytes(pktRdBytes),
    .setupPulse(setupPulse), .xferIrq(xferIrq), .setupOvf(setupOvf)
  );

  typedef struct {
    logic [31:0] expReg;
    logic        expEn;
    logic        expIrq;
    logic        expOvf;
    string       tag;
  } expItem_t;

  expItem_t sbq[$];

  // reference state
  logic [1:0] mSet = '0;
  logic       mPkt = 1'b0;
  logic [6:0] mSize = '0;
  logic       mEn = 1'b0;

  function automatic logic [31:0] mkReg(logic [1:0] s, logic p, logic [6:0] z);
    return {1'b0, s, 9'b0, p, 12'b0, z};
  endfunction

  task automatic step(input logic wr, input logic [31:0] wd, input logic enSet,
                      input logic pw, input logic pr, input logic [6:0] nb,
                      input logic su, input string tag);
    expItem_t it;
    logic irq = 1'b0;
    logic ovf = 1'b0;
    @(negedge clk);
    regWrEn = wr; regWrData = wd; epEnableSet = enSet;
    pktWrPulse = pw; pktRdPulse = pr; pktRdBytes = nb; setupPulse = su;
    if (!mEn) begin
      if (wr) begin
        mSet = wd[30:29]; mPkt = wd[19]; mSize = wd[6:0];
      end
      if (enSet) mEn = 1'b1;
    end else begin
      if (pw) mPkt = 1'b0;
      if (su) begin
        if (mSet != 2'b00) mSet = mSet - 2'd1;
        else ovf = 1'b1;
      end
      if (pr) begin
        logic fin;
        fin = (nb >= mSize) || (nb < 7'd64);
        mSize = (nb >= mSize) ? 7'd0 : mSize - nb;
        if (fin) begin
          mEn = 1'b0; irq = 1'b1;
        end
      end
    end
    it.expReg = mkReg(mSet, mPkt, mSize);
    it.expEn = mEn; it.expIrq = irq; it.expOvf = ovf; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 7'd0, 1'b0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        expItem_t it;
        it = sbq.pop_front();
        testCnt++;
        if (regRdData !== it.expReg || epEnable !== it.expEn ||
            xferIrq !== it.expIrq || setupOvf !== it.expOvf) begin
          failCnt++;
          $display("FAIL %s: reg=%h en=%b irq=%b ovf=%b expected reg=%h en=%b irq=%b ovf=%b",
                   it.tag, regRdData, epEnable, xferIrq, setupOvf,
                   it.expReg, it.expEn, it.expIrq, it.expOvf);
        end
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle("R1 reset state");
    // R2 field layout, reserved bits read zero
    step(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 7'd0, 1'b0, "R2 all-ones write");
    step(1'b1, 32'h2008_0040, 1'b0, 1'b0, 1'b0, 7'd0, 1'b0, "R2 program 1 setup, 64 bytes");
    // R9 strobes while disabled
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 7'd10, 1'b1, "R9 strobes ignored while disabled");
    // R11 enable
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 7'd0, 1'b0, "R11 enable set");
    // R3 write ignored while enabled
    step(1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 7'd0, 1'b0, "R3 write while enabled");
    // R8 setup budget and overflow
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 7'd0, 1'b1, "R8 setup decrement");
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 7'd0, 1'b1, "R8 setup overflow");
    idle("R8 overflow one cycle");
    // R10 + R6: write and drain same cycle, drain empties the budget
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 7'd64, 1'b0, "R10 R6 write+drain, completion");
    idle("R6 irq single cycle");
    // R5 saturation and R6 completion on zero budget
    step(1'b1, 32'h6008_007F, 1'b0, 1'b0, 1'b0, 7'd0, 1'b0, "R2 program 127 bytes");
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 7'd0, 1'b0, "R11 enable again");
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 7'd0, 1'b0, "R4 packet written");
    step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 7'd0, 1'b0, "R4 packet count stays zero");
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 7'd64, 1'b0, "R5 full packet drained");
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 7'd64, 1'b0, "R5 R6 saturating drain completes");
    idle("R6 after completion");
    // R7 short packet
    step(1'b1, 32'h0008_0064, 1'b0, 1'b0, 1'b0, 7'd0, 1'b0, "R2 program 100 bytes");
    step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 7'd0, 1'b0, "R11 enable third");
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 7'd20, 1'b0, "R7 short packet completes");
    step(1'b1, 32'h0000_0050, 1'b1, 1'b0, 1'b0, 7'd0, 1'b0, "R2 R11 reprogram and enable");
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 7'd0, 1'b0, "R7 zero-length packet completes");
    idle("R9 quiet after completion");
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule